// File: doc/BRIEF.md
# Single-Channel Block-Copy DMA Engine

This block is one DMA channel. Software loads a source address, a destination address and a byte count through a small word-indexed register port. It then writes the control word with the go bit set. The channel requests the system bus, and on each beat it reads one word from the source and writes that word to the destination. The addresses step by the word size in the direction that software chose, and the count falls by the word size. When the last beat has been written, the channel raises an interrupt. The interrupt stays high until software clears it.

Three bus-sharing policies decide when the channel asks for the bus:
- **Burst** holds the request for the whole block.
- **Cycle-stealing** releases the request for one cycle after every beat, so the CPU can get in between beats.
- **Transparent** requests the bus, and moves data, only in cycles where the CPU's idle sideband is high.

In every mode, a memory cycle needs both the channel's request and the arbiter's grant. If the grant is taken away in the middle of a block, the channel waits with its addresses, count and any word it has already read kept intact.

Top module: `dmac_channel`

## Requirements
- R1: Registers sit at word indices 0 (source address), 1 (destination address), 2 (byte count), 3 (control) and 4 (status). After reset, every register reads 0, and `irq` and `bus_req` are low.
- R2: The control word has go in bit 0, descending in bit 1, and the mode in bits 3:2 (0 burst, 1 cycle-steal, 2 transparent, 3 behaves as burst). Writing go=1 when the count is below 4 bytes sets status bit 1 (error) and raises no bus request. Writing go=1 with a count of at least 4 starts the transfer and clears done, error and position.
- R3: `mem_rd` or `mem_wr` is asserted only in a cycle where both `bus_req` and `bus_gnt` are high.
- R4: Each beat issues one read of the source address and then one write of the word that was read to the destination address. After the beat, both addresses move by 4 (up when bit 1 was 0, down when it was 1) and the count drops by 4.
- R5: In burst mode, once `bus_req` has risen it stays high until the block has finished.
- R6: In cycle-stealing mode, `bus_req` is low in the cycle after each beat's write. A block of N words therefore shows N rising edges of `bus_req`.
- R7: In transparent mode, no memory cycle takes place while `cpu_idle` is low.
- R8: When `bus_gnt` is removed in the middle of a block, no memory cycle happens. The transfer resumes when the grant returns, and every destination word is still correct.
- R9: When the last write completes, status bit 0 (done) sets and `irq` rises. `irq` stays high until status is written with bit 0 = 1. Writing status bit 1 = 1 clears the error bit.
- R10: While a transfer is active, writes to the source, destination, count and control registers are ignored.
- R11: Status bit 2 and control bit 0 read as busy, and status bits 31:16 hold the number of words moved in the current or last block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from `reg_addr`) |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| cpu_idle | input | 1 | High in cycles where the CPU does not need the bus |
| mem_rd | output | 1 | Memory read strobe; data is expected on `mem_rdata` in the following cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| irq | output | 1 | Completion interrupt, held until cleared |

## Verification
The embedded properties watch, on every cycle, that memory strobes appear only under request and grant, and only in idle cycles when the mode is transparent. They also watch that burst mode never drops its request mid-block and that cycle-stealing mode always drops it after a write. Further properties cover a rejected start raising no request, the count stepping down by one word per beat, register values holding across ignored writes, and the interrupt staying high until it is cleared. The bench scenarios are needed for what only shows over a whole block:
- a scoreboard compares each destination write with the expected address and data in order, in both address directions;
- the request edges in cycle-stealing mode are counted;
- data stays intact across grant loss and sparse idle cycles;
- the final register values and position field read back correctly.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int REG_W  = 32;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        RA_SRC  = 3'd0,
        RA_DST  = 3'd1,
        RA_CNT  = 3'd2,
        RA_CTRL = 3'd3,
        RA_STAT = 3'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        XM_BURST = 2'd0,
        XM_STEAL = 2'd1,
        XM_IDLE  = 2'd2,
        XM_RSVD  = 2'd3
    } xfer_mode_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       descend;
    } xfer_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_READ  = 2'd1,
        SQ_WRITE = 2'd2
    } seq_state_e;

    // control word fields
    localparam int CTRL_GO    = 0;
    localparam int CTRL_DESC  = 1;
    localparam int CTRL_MODE  = 2;
    // status word fields
    localparam int ST_DONE    = 0;
    localparam int ST_ERR     = 1;
    localparam int ST_BUSY    = 2;
    localparam int ST_POS     = 16;
    localparam int POS_W      = REG_W - ST_POS;

    function automatic logic mode_steals(input xfer_mode_e m);
        return m == XM_STEAL;
    endfunction

    function automatic logic mode_waits_idle(input xfer_mode_e m);
        return m == XM_IDLE;
    endfunction

endpackage

// File: rtl/dmac_regfile.sv
module dmac_regfile
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int WB     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              step,
    input  logic              finish,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [CNT_W-1:0]  cnt_q,
    output xfer_cfg_t         cfg_q,
    output logic              busy_q,
    output logic              err_q,
    output logic              start_go,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] ASTEP = ADDR_W'(WB);
    localparam logic [CNT_W-1:0]  CSTEP = CNT_W'(WB);

    logic             done_q;
    logic [POS_W-1:0] pos_q;
    logic             wr_src, wr_dst, wr_cnt, wr_ctrl, wr_stat;
    logic             start_req, cnt_ok;
    logic [ADDR_W-1:0] src_nx, dst_nx;

    always_comb begin
        wr_src    = reg_we && !busy_q && (reg_addr == RA_SRC);
        wr_dst    = reg_we && !busy_q && (reg_addr == RA_DST);
        wr_cnt    = reg_we && !busy_q && (reg_addr == RA_CNT);
        wr_ctrl   = reg_we && !busy_q && (reg_addr == RA_CTRL);
        wr_stat   = reg_we && (reg_addr == RA_STAT);
        cnt_ok    = cnt_q >= CSTEP;
        start_req = wr_ctrl && reg_wdata[CTRL_GO];
        start_go  = start_req && cnt_ok;
        src_nx    = cfg_q.descend ? src_q - ASTEP : src_q + ASTEP;
        dst_nx    = cfg_q.descend ? dst_q - ASTEP : dst_q + ASTEP;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q  <= '0;
            dst_q  <= '0;
            cnt_q  <= '0;
            cfg_q  <= '{mode: XM_BURST, descend: 1'b0};
            busy_q <= 1'b0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
            pos_q  <= '0;
        end else begin
            if (wr_src)      src_q <= reg_wdata[ADDR_W-1:0];
            else if (step)   src_q <= src_nx;

            if (wr_dst)      dst_q <= reg_wdata[ADDR_W-1:0];
            else if (step)   dst_q <= dst_nx;

            if (wr_cnt)      cnt_q <= reg_wdata[CNT_W-1:0];
            else if (step)   cnt_q <= cnt_q - CSTEP;

            if (wr_ctrl) begin
                cfg_q.mode    <= xfer_mode_e'(reg_wdata[CTRL_MODE +: 2]);
                cfg_q.descend <= reg_wdata[CTRL_DESC];
            end

            if (start_go)    busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;

            if (start_go)    pos_q <= '0;
            else if (step)   pos_q <= pos_q + 1'b1;

            if (start_go)                        done_q <= 1'b0;
            else if (finish)                     done_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_DONE]) done_q <= 1'b0;

            if (start_req && !cnt_ok)            err_q <= 1'b1;
            else if (start_go)                   err_q <= 1'b0;
            else if (wr_stat && reg_wdata[ST_ERR]) err_q <= 1'b0;
        end
    end

    assign irq = done_q;

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_SRC:  reg_rdata = REG_W'(src_q);
            RA_DST:  reg_rdata = REG_W'(dst_q);
            RA_CNT:  reg_rdata = REG_W'(cnt_q);
            RA_CTRL: begin
                reg_rdata[CTRL_GO]        = busy_q;
                reg_rdata[CTRL_DESC]      = cfg_q.descend;
                reg_rdata[CTRL_MODE +: 2] = cfg_q.mode;
            end
            RA_STAT: begin
                reg_rdata[ST_DONE]        = done_q;
                reg_rdata[ST_ERR]         = err_q;
                reg_rdata[ST_BUSY]        = busy_q;
                reg_rdata[ST_POS +: POS_W] = pos_q;
            end
            default: reg_rdata = '0;
        endcase
    end

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> cnt_q == $past(cnt_q) - CSTEP);

    // R10
    src_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !step) |=> src_q == $past(src_q));

    // R10
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q |=> cfg_q == $past(cfg_q));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !(reg_we && reg_addr == RA_STAT && reg_wdata[ST_DONE]) && !start_go) |=> irq);

endmodule

// File: rtl/dmac_bus_policy.sv
module dmac_bus_policy
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       busy,
    input  xfer_mode_e mode,
    input  logic       bus_gnt,
    input  logic       cpu_idle,
    input  logic       beat_end,
    output logic       bus_req,
    output logic       mem_ok
);

    logic gap_q;

    always_ff @(posedge clk) begin
        if (rst) gap_q <= 1'b0;
        else     gap_q <= busy && beat_end && mode_steals(mode);
    end

    always_comb begin
        bus_req = busy && !gap_q && (!mode_waits_idle(mode) || cpu_idle);
        mem_ok  = bus_req && bus_gnt;
    end

    // R5
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bus_req) && busy && (mode == XM_BURST)) |-> bus_req);

    // R6
    steal_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_end && busy && (mode == XM_STEAL)) |=> !bus_req);

endmodule

// File: rtl/dmac_sequencer.sv
module dmac_sequencer
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int WB     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_go,
    input  logic              mem_ok,
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [CNT_W-1:0]  cnt,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              step,
    output logic              finish
);

    localparam logic [CNT_W-1:0] LAST_LIM = CNT_W'(2 * WB);

    seq_state_e        st_q, st_nx;
    logic              fresh_q;
    logic [DATA_W-1:0] hold_q;
    logic              last;

    always_comb begin
        last      = cnt < LAST_LIM;
        st_nx     = st_q;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_addr  = '0;
        mem_wdata = fresh_q ? mem_rdata : hold_q;
        step      = 1'b0;
        finish    = 1'b0;
        case (st_q)
            SQ_IDLE: if (start_go) st_nx = SQ_READ;
            SQ_READ: begin
                mem_addr = src;
                if (mem_ok) begin
                    mem_rd = 1'b1;
                    st_nx  = SQ_WRITE;
                end
            end
            SQ_WRITE: begin
                mem_addr = dst;
                if (mem_ok) begin
                    mem_wr = 1'b1;
                    step   = 1'b1;
                    finish = last;
                    st_nx  = last ? SQ_IDLE : SQ_READ;
                end
            end
            default: st_nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            fresh_q <= 1'b0;
            hold_q  <= '0;
        end else begin
            st_q    <= st_nx;
            fresh_q <= mem_rd;
            if (fresh_q) hold_q <= mem_rdata;
        end
    end

    // R4
    no_double_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R4
    no_double_write_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> !mem_wr);

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    input  logic              cpu_idle,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              irq
);

    localparam int WB = DATA_W / 8;

    logic [ADDR_W-1:0] src_q, dst_q;
    logic [CNT_W-1:0]  cnt_q;
    xfer_cfg_t         cfg_q;
    logic              busy_q, err_q, start_go;
    logic              step, finish, mem_ok;

    dmac_regfile #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .WB(WB)) u_regs (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .step(step), .finish(finish),
        .src_q(src_q), .dst_q(dst_q), .cnt_q(cnt_q), .cfg_q(cfg_q),
        .busy_q(busy_q), .err_q(err_q), .start_go(start_go), .irq(irq)
    );

    dmac_bus_policy u_policy (
        .clk(clk), .rst(rst),
        .busy(busy_q), .mode(cfg_q.mode),
        .bus_gnt(bus_gnt), .cpu_idle(cpu_idle), .beat_end(step),
        .bus_req(bus_req), .mem_ok(mem_ok)
    );

    dmac_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .WB(WB)) u_seq (
        .clk(clk), .rst(rst),
        .start_go(start_go), .mem_ok(mem_ok),
        .src(src_q), .dst(dst_q), .cnt(cnt_q),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .step(step), .finish(finish)
    );

    // R3, R8
    owned_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd || mem_wr) |-> (bus_req && bus_gnt));

    // R7
    idle_only_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && cfg_q.mode == XM_IDLE) |-> cpu_idle);

    // R2
    err_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !busy_q) |-> !bus_req);

    // R9
    done_irq_chk: assert property (@(posedge clk) disable iff (rst)
        finish |=> (irq && !busy_q));

endmodule

// File: tb/tb_dmac_channel.sv
`timescale 1ns/1ps
module tb_dmac_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        bus_req;
    logic        bus_gnt = 1'b1;
    logic        cpu_idle = 1'b1;
    logic        mem_rd, mem_wr;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        irq;

    always #2 clk = ~clk;

    dmac_channel dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
        .bus_gnt(bus_gnt), .cpu_idle(cpu_idle), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    logic [63:0] sb_q [$];

    int cyc = 0;
    int gnt_pat = 0;
    int idle_pat = 0;
    int req_rises = 0;
    int gnt_viol = 0;
    int busy_idle_ops = 0;
    int gnt_drops = 0;
    logic prev_req = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // input pattern drivers, away from the sampling edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        bus_gnt  = (gnt_pat == 0) ? 1'b1 : ((cyc % 7) < 4);
        cpu_idle = (idle_pat == 0) ? 1'b1 : ((cyc % 3) == 0);
    end

    // memory model and scoreboard monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (bus_req && !prev_req) req_rises++;
            prev_req = bus_req;
            if (bus_req && !bus_gnt) gnt_drops++;
            if ((mem_rd || mem_wr) && !bus_gnt) gnt_viol++;
            if ((mem_rd || mem_wr) && !cpu_idle) busy_idle_ops++;
            if (mem_rd) mem_rdata = mem[mem_addr[9:2]];
            if (mem_wr) begin
                mem[mem_addr[9:2]] = mem_wdata;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", mem_addr, 32'h0);
                end else begin
                    logic [63:0] e;
                    e = sb_q.pop_front();
                    chk(mem_addr == e[63:32], "R4 dest address", mem_addr, e[63:32]);
                    chk(mem_wdata == e[31:0], "R4 dest data", mem_wdata, e[31:0]);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    // driver: load memory, push expected writes, program and start
    task automatic launch(input logic [31:0] src, input logic [31:0] dst, input int words,
                          input bit desc, input logic [1:0] mode, input logic [7:0] tag);
        for (int i = 0; i < words; i++) begin
            logic [31:0] sa, da, v;
            sa = desc ? src - 32'(4 * i) : src + 32'(4 * i);
            da = desc ? dst - 32'(4 * i) : dst + 32'(4 * i);
            v  = {8'hC3, tag, 8'(i * 17), 8'(i)};
            mem[sa[9:2]] = v;
            sb_q.push_back({da, v});
        end
        wr(3'd0, src);
        wr(3'd1, dst);
        wr(3'd2, 32'(4 * words));
        wr(3'd3, {28'h0, mode, desc, 1'b1});
    endtask

    task automatic wait_irq(input string tag);
        int n;
        n = 0;
        while (!irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(irq == 1'b1, tag, {31'h0, irq}, 32'h1);
    endtask

    task automatic clear_done();
        wr(3'd4, 32'h1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int rises0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), r);
            chk(r == 32'h0, "R1 reset register", r, 32'h0);
        end
        chk(irq == 1'b0, "R1 reset irq", {31'h0, irq}, 32'h0);
        chk(bus_req == 1'b0, "R1 reset bus_req", {31'h0, bus_req}, 32'h0);

        // R4 R5 R11 burst ascending, 4 words
        rises0 = req_rises;
        launch(32'h100, 32'h200, 4, 1'b0, 2'd0, 8'h11);
        wait_irq("R9 burst irq");
        chk(sb_q.size() == 0, "R4 burst all written", 32'(sb_q.size()), 32'h0);
        chk(req_rises - rises0 == 1, "R5 burst single request", 32'(req_rises - rises0), 32'h1);
        rd(3'd4, r);
        chk(r == 32'h0004_0001, "R11 status after burst", r, 32'h0004_0001);
        rd(3'd0, r);
        chk(r == 32'h110, "R4 source advanced", r, 32'h110);
        rd(3'd2, r);
        chk(r == 32'h0, "R4 count exhausted", r, 32'h0);
        repeat (5) @(negedge clk);
        chk(irq == 1'b1, "R9 irq held", {31'h0, irq}, 32'h1);
        clear_done();
        @(negedge clk);
        chk(irq == 1'b0, "R9 irq cleared by W1C", {31'h0, irq}, 32'h0);

        // R2 zero/short count rejected
        rises0 = req_rises;
        wr(3'd2, 32'h2);
        wr(3'd3, 32'h1);
        repeat (10) @(negedge clk);
        chk(req_rises == rises0, "R2 no request on short count", 32'(req_rises - rises0), 32'h0);
        rd(3'd4, r);
        chk(r == 32'h0004_0002, "R2 error bit set", r, 32'h0004_0002);
        chk(irq == 1'b0, "R2 no irq on error", {31'h0, irq}, 32'h0);
        wr(3'd4, 32'h2);
        rd(3'd4, r);
        chk(r[1] == 1'b0, "R9 error cleared by W1C", r, 32'h0);

        // R6 cycle stealing, 3 words
        rises0 = req_rises;
        launch(32'h040, 32'h300, 3, 1'b0, 2'd1, 8'h22);
        wait_irq("R6 steal irq");
        chk(req_rises - rises0 == 3, "R6 request edges", 32'(req_rises - rises0), 32'h3);
        chk(sb_q.size() == 0, "R6 all written", 32'(sb_q.size()), 32'h0);
        clear_done();

        // R7 transparent with sparse idle cycles
        busy_idle_ops = 0;
        idle_pat = 1;
        launch(32'h080, 32'h380, 5, 1'b0, 2'd2, 8'h33);
        wait_irq("R7 transparent irq");
        idle_pat = 0;
        chk(busy_idle_ops == 0, "R7 memory cycle in busy CPU cycle", 32'(busy_idle_ops), 32'h0);
        chk(sb_q.size() == 0, "R7 all written", 32'(sb_q.size()), 32'h0);
        clear_done();

        // R8 grant removed mid-burst
        gnt_viol = 0;
        gnt_drops = 0;
        gnt_pat = 1;
        launch(32'h0C0, 32'h240, 6, 1'b0, 2'd0, 8'h44);
        wait_irq("R8 paused burst irq");
        gnt_pat = 0;
        chk(gnt_drops > 0, "R8 grant actually dropped", 32'(gnt_drops), 32'h1);
        chk(gnt_viol == 0, "R8 memory cycle without grant", 32'(gnt_viol), 32'h0);
        chk(sb_q.size() == 0, "R8 all written", 32'(sb_q.size()), 32'h0);
        rd(3'd4, r);
        chk(r[31:16] == 16'd6, "R11 position after paused burst", {16'h0, r[31:16]}, 32'h6);
        clear_done();

        // R4 descending direction
        launch(32'h0FC, 32'h3FC, 4, 1'b1, 2'd0, 8'h55);
        wait_irq("R4 descending irq");
        chk(sb_q.size() == 0, "R4 descending all written", 32'(sb_q.size()), 32'h0);
        rd(3'd1, r);
        chk(r == 32'h3EC, "R4 destination moved down", r, 32'h3EC);
        clear_done();

        // R10 writes ignored while busy
        gnt_pat = 1;
        launch(32'h020, 32'h2C0, 4, 1'b0, 2'd0, 8'h66);
        wr(3'd3, 32'h7);
        wr(3'd0, 32'h0);
        rd(3'd3, r);
        chk(r == 32'h1, "R10 control unchanged and busy", r, 32'h1);
        wait_irq("R10 irq");
        gnt_pat = 0;
        chk(sb_q.size() == 0, "R10 transfer intact", 32'(sb_q.size()), 32'h0);
        rd(3'd0, r);
        chk(r == 32'h030, "R10 source write ignored", r, 32'h030);
        rd(3'd3, r);
        chk(r == 32'h0, "R11 control idle readback", r, 32'h0);
        clear_done();

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule